// File: doc/BRIEF.md
# Multi-Queue In-Order Scheduler with Shared Issue Ports

This block sits between instruction allocation and the execution units. It holds a fixed number of small in-order scheduling queues. Each queue accepts one operation per cycle. An operation carries a target-port field, two source-operand tags with their initial ready bits, and an opaque payload. Only the oldest entry of a queue is a candidate for issue. It becomes a candidate once both source operands are ready and the execution unit behind its target port is not busy.

A wakeup broadcast carries a produced tag. It sets the matching source-ready bits in every stored entry, and also in an entry that is being enqueued in the same cycle. Four issue ports are shared by all queues: a load port, a store port and two execution ports. Each port has its own round-robin arbiter that picks one requesting queue per cycle. Ordering is therefore kept inside each queue, while separate queues may issue ahead of one another or side by side on different ports. A flush discards the contents of every queue.

The issue outputs are combinational from the queue heads and the busy inputs in the current cycle. The selected entry leaves its queue at the next clock edge.

Top module: `sq_sched`

## Requirements
- R1: After reset every queue is empty: all `enq_ready` bits are high and no `iss_valid` bit is set. Each queue holds exactly DEPTH entries (default 8).
- R2: A queue accepts an entry on a clock edge where its `enq_valid` and `enq_ready` are both high. `enq_ready` is low while the queue holds DEPTH entries or `flush` is high. An entry offered while `enq_ready` is low is discarded and never issues.
- R3: Only the oldest entry of a queue may issue. Entries of one queue issue in arrival order, and a blocked oldest entry holds back every younger entry of that queue.
- R4: An entry issues only when both of its source-ready bits are set. A wakeup with `wk_valid` high sets every source-ready bit whose tag equals `wk_tag`, in stored entries and in a same-cycle enqueue. An entry woken at an edge can issue in the cycle that follows that edge, not earlier.
- R5: No issue is made on port p while `unit_busy[p]` is high. When the bit falls, a waiting ready head issues in that same cycle.
- R6: The port field encodes 0 = load, 1 = store, 2 = execution A, 3 = execution B. An entry issues only on the port its field names. `iss_queue[p]` carries the number of the source queue and `iss_payload[p]` carries the payload.
- R7: Each port grants at most one queue per cycle, and each queue issues at most once per cycle. Port arbitration is round-robin: after queue q is granted on port p, queue q+1 (wrapping) has the highest priority on p.
- R8: Queues are independent. An entry of one queue may issue while an older entry of another queue waits, and different queues may issue in the same cycle on different ports.
- R9: `flush` suppresses all issue in its cycle and empties every queue at the next edge. An enqueue offered during a flush is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Discard all queue contents |
| enq_valid | input | NQ | Per-queue enqueue request |
| enq_port | input | NQ*2 | Per-queue target port field |
| enq_src0_tag | input | NQ*TAG_W | First source tag per queue |
| enq_src0_rdy | input | NQ | First source already ready |
| enq_src1_tag | input | NQ*TAG_W | Second source tag per queue |
| enq_src1_rdy | input | NQ | Second source already ready |
| enq_payload | input | NQ*PAY_W | Opaque payload per queue |
| enq_ready | output | NQ | Queue can accept this cycle |
| wk_valid | input | 1 | Wakeup broadcast valid |
| wk_tag | input | TAG_W | Tag being produced |
| unit_busy | input | 4 | Per-port execution unit busy |
| iss_valid | output | 4 | Per-port issue valid |
| iss_queue | output | 4*QIDX_W | Source queue of each issue |
| iss_payload | output | 4*PAY_W | Payload of each issue |

## Verification
The assertions assume that `enq_port` holds one of the four legal codes and that `rst_n` is low from time zero. They keep a count of each queue's occupancy built only from port activity, and that count relies on the bench never changing inputs near the active edge. The stimulus drives every input on the falling edge, uses only legal port codes, and holds reset low from the start. It fills queues to the limit only while the target unit is busy, so the occupancy count can be checked against `enq_ready` at full depth.

// File: rtl/sq_pkg.sv
// Package: shared widths, port codes and the queue entry type.
// Assumes exactly four issue ports, encoded in a two-bit field.
package sq_pkg;
    localparam int TAG_W  = 5;
    localparam int PAY_W  = 8;
    localparam int NPORT  = 4;
    localparam int PORT_W = $clog2(NPORT);

    localparam logic [PORT_W-1:0] PORT_LOAD  = 2'd0;
    localparam logic [PORT_W-1:0] PORT_STORE = 2'd1;
    localparam logic [PORT_W-1:0] PORT_EXA   = 2'd2;
    localparam logic [PORT_W-1:0] PORT_EXB   = 2'd3;

    typedef struct packed {
        logic [PORT_W-1:0] port;
        logic [TAG_W-1:0]  tag0;
        logic              rdy0;
        logic [TAG_W-1:0]  tag1;
        logic              rdy1;
        logic [PAY_W-1:0]  pay;
    } sq_entry_t;

    // Return the entry with the source-ready bits set that match a broadcast tag.
    function automatic sq_entry_t sq_wake(input sq_entry_t e, input logic v,
                                          input logic [TAG_W-1:0] t);
        sq_entry_t r;
        r = e;
        if (v && e.tag0 == t) r.rdy0 = 1'b1;
        if (v && e.tag1 == t) r.rdy1 = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/sq_queue.sv
// Module: one in-order scheduling queue held as a circular buffer.
// Only the head can leave, under the pop input. Stored entries and a
// same-cycle enqueue see the wakeup broadcast. Assumes the caller pops
// only while the head is valid. A same-cycle pop does not raise enq_ready.
module sq_queue
    import sq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              enq_valid,
    input  sq_entry_t         enq_entry,
    output logic              enq_ready,
    input  logic              wk_valid,
    input  logic [TAG_W-1:0]  wk_tag,
    input  logic              pop,
    output logic              head_valid,
    output logic              head_ready,
    output logic [PORT_W-1:0] head_port,
    output logic [PAY_W-1:0]  head_pay
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    sq_entry_t          mem [DEPTH];
    logic [IDX_W-1:0]   head_q, tail_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               push;
    sq_entry_t          head_e;

    // Advance a buffer index with wrap at DEPTH.
    function automatic logic [IDX_W-1:0] nxt(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Accept when not full and not flushing.
    assign enq_ready = (cnt_q != CNT_W'(DEPTH)) && !flush;
    assign push      = enq_valid && enq_ready;

    // Head view for the arbiters.
    assign head_e     = mem[head_q];
    assign head_valid = (cnt_q != '0);
    assign head_ready = head_e.rdy0 && head_e.rdy1;
    assign head_port  = head_e.port;
    assign head_pay   = head_e.pay;

    // Storage: wake stored entries, write the new entry with the wakeup merged in.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (push && tail_q == IDX_W'(i))
                mem[i] <= sq_wake(enq_entry, wk_valid, wk_tag);
            else
                mem[i] <= sq_wake(mem[i], wk_valid, wk_tag);
        end
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (push) tail_q <= nxt(tail_q);
            if (pop)  head_q <= nxt(head_q);
            cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
        end
    end
endmodule

// File: rtl/sq_port_arb.sv
// Module: round-robin arbiter for one issue port.
// The priority pointer moves to one past the last granted requester.
// Assumes NQ is at least 2.
module sq_port_arb #(
    parameter int NQ = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NQ-1:0]         req,
    output logic [NQ-1:0]         gnt,
    output logic [$clog2(NQ)-1:0] gnt_idx
);
    localparam int QW = $clog2(NQ);

    logic [QW-1:0] ptr_q;

    // Scan requesters starting at the priority pointer.
    always_comb begin
        int  idx;
        logic found;
        gnt     = '0;
        gnt_idx = '0;
        found   = 1'b0;
        for (int k = 0; k < NQ; k++) begin
            idx = int'(ptr_q) + k;
            if (idx >= NQ) idx = idx - NQ;
            if (!found && req[idx]) begin
                gnt[idx] = 1'b1;
                gnt_idx  = QW'(idx);
                found    = 1'b1;
            end
        end
    end

    // Rotate priority after every grant.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (|req)
            ptr_q <= (gnt_idx == QW'(NQ - 1)) ? '0 : gnt_idx + 1'b1;
    end
endmodule

// File: rtl/sq_sched.sv
// Module: top of the scheduler. NQ in-order queues share four issue ports.
// Each port has its own round-robin arbiter. Issue is combinational from the
// registered heads and the busy inputs, and the granted head pops at the edge.
// Assumes enq_port carries legal codes only.
module sq_sched
    import sq_pkg::*;
#(
    parameter int NQ     = 4,
    parameter int DEPTH  = 8,
    parameter int QIDX_W = $clog2(NQ)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  flush,
    input  logic [NQ-1:0]         enq_valid,
    input  logic [NQ*PORT_W-1:0]  enq_port,
    input  logic [NQ*TAG_W-1:0]   enq_src0_tag,
    input  logic [NQ-1:0]         enq_src0_rdy,
    input  logic [NQ*TAG_W-1:0]   enq_src1_tag,
    input  logic [NQ-1:0]         enq_src1_rdy,
    input  logic [NQ*PAY_W-1:0]   enq_payload,
    output logic [NQ-1:0]         enq_ready,
    input  logic                  wk_valid,
    input  logic [TAG_W-1:0]      wk_tag,
    input  logic [NPORT-1:0]      unit_busy,
    output logic [NPORT-1:0]      iss_valid,
    output logic [NPORT*QIDX_W-1:0] iss_queue,
    output logic [NPORT*PAY_W-1:0]  iss_payload
);
    logic [NQ-1:0]     h_valid, h_ready, pop;
    logic [PORT_W-1:0] h_port [NQ];
    logic [PAY_W-1:0]  h_pay  [NQ];
    logic [NQ-1:0]     req  [NPORT];
    logic [NQ-1:0]     gnt  [NPORT];
    logic [QIDX_W-1:0] gidx [NPORT];

    genvar q, p;
    generate
        for (q = 0; q < NQ; q++) begin : g_q
            sq_entry_t e_in;
            // Pack the flat enqueue fields for this queue.
            always_comb begin
                e_in.port = enq_port[q*PORT_W +: PORT_W];
                e_in.tag0 = enq_src0_tag[q*TAG_W +: TAG_W];
                e_in.rdy0 = enq_src0_rdy[q];
                e_in.tag1 = enq_src1_tag[q*TAG_W +: TAG_W];
                e_in.rdy1 = enq_src1_rdy[q];
                e_in.pay  = enq_payload[q*PAY_W +: PAY_W];
            end

            sq_queue #(.DEPTH(DEPTH)) i_queue (
                .clk        (clk),
                .rst_n      (rst_n),
                .flush      (flush),
                .enq_valid  (enq_valid[q]),
                .enq_entry  (e_in),
                .enq_ready  (enq_ready[q]),
                .wk_valid   (wk_valid),
                .wk_tag     (wk_tag),
                .pop        (pop[q]),
                .head_valid (h_valid[q]),
                .head_ready (h_ready[q]),
                .head_port  (h_port[q]),
                .head_pay   (h_pay[q])
            );

            // A queue pops when any port granted it.
            always_comb begin
                pop[q] = 1'b0;
                for (int k = 0; k < NPORT; k++) pop[q] = pop[q] | gnt[k][q];
            end
        end

        for (p = 0; p < NPORT; p++) begin : g_p
            // Requests: ready head aimed at this port, unit free, no flush.
            always_comb begin
                for (int k = 0; k < NQ; k++)
                    req[p][k] = h_valid[k] && h_ready[k] && !flush &&
                                !unit_busy[p] && (h_port[k] == PORT_W'(p));
            end

            sq_port_arb #(.NQ(NQ)) i_arb (
                .clk     (clk),
                .rst_n   (rst_n),
                .req     (req[p]),
                .gnt     (gnt[p]),
                .gnt_idx (gidx[p])
            );

            // Drive the port outputs from the granted head.
            assign iss_valid[p]                    = |gnt[p];
            assign iss_queue[p*QIDX_W +: QIDX_W]   = gidx[p];
            assign iss_payload[p*PAY_W +: PAY_W]   = h_pay[gidx[p]];
        end
    endgenerate
endmodule

// File: rtl/sq_sched_chk.sv
// Module: property checker for sq_sched, attached by bind.
// It keeps its own occupancy count per queue, built from port activity only.
module sq_sched_chk #(
    parameter int NQ     = 4,
    parameter int DEPTH  = 8,
    parameter int NPORT  = 4,
    parameter int QIDX_W = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      flush,
    input logic [NQ-1:0]             enq_valid,
    input logic [NQ-1:0]             enq_ready,
    input logic [NPORT-1:0]          unit_busy,
    input logic [NPORT-1:0]          iss_valid,
    input logic [NPORT*QIDX_W-1:0]   iss_queue
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CNT_W-1:0] mcnt [NQ];

    // Occupancy count from accepted enqueues and observed issues.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int q = 0; q < NQ; q++) mcnt[q] <= '0;
        end else begin
            for (int q = 0; q < NQ; q++) begin
                logic [CNT_W-1:0] pops;
                pops = '0;
                for (int p = 0; p < NPORT; p++)
                    if (iss_valid[p] && iss_queue[p*QIDX_W +: QIDX_W] == QIDX_W'(q))
                        pops = pops + 1'b1;
                if (flush) mcnt[q] <= '0;
                else mcnt[q] <= mcnt[q] + CNT_W'(enq_valid[q] && enq_ready[q]) - pops;
            end
        end
    end

    // R1: nothing issues in the first cycle out of reset.
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> iss_valid == '0);

    // R9: no issue during flush, and queues are empty right after it.
    a_r9_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> iss_valid == '0);
    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flush) |-> iss_valid == '0);

    genvar q, p, b;
    generate
        for (q = 0; q < NQ; q++) begin : g_cq
            // R2: accept signal tracks occupancy and flush.
            a_r2_ready_vs_count: assert property (@(posedge clk) disable iff (!rst_n)
                enq_ready[q] == (!flush && mcnt[q] < CNT_W'(DEPTH)));
        end
        for (p = 0; p < NPORT; p++) begin : g_cp
            // R5: a busy unit never receives an issue.
            a_r5_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
                unit_busy[p] |-> !iss_valid[p]);
            // R3: an issue always comes from a queue that holds an entry.
            a_r3_issue_has_entry: assert property (@(posedge clk) disable iff (!rst_n)
                iss_valid[p] |-> mcnt[iss_queue[p*QIDX_W +: QIDX_W]] != '0);
            for (b = p + 1; b < NPORT; b++) begin : g_pair
                // R7: one queue never issues on two ports at once.
                a_r7_one_per_queue: assert property (@(posedge clk) disable iff (!rst_n)
                    (iss_valid[p] && iss_valid[b]) |->
                    iss_queue[p*QIDX_W +: QIDX_W] != iss_queue[b*QIDX_W +: QIDX_W]);
            end
        end
    endgenerate
endmodule

bind sq_sched sq_sched_chk #(
    .NQ(NQ), .DEPTH(DEPTH), .NPORT(sq_pkg::NPORT), .QIDX_W(QIDX_W)
) i_sq_sched_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .enq_valid (enq_valid),
    .enq_ready (enq_ready),
    .unit_busy (unit_busy),
    .iss_valid (iss_valid),
    .iss_queue (iss_queue)
);

// File: tb/test_sq_sched.sv
// Bench: directed sweeps over the default four-queue, depth-8 configuration.
`timescale 1ns/1ps
module test_sq_sched;
    localparam int NQ = 4, DEPTH = 8, QW = 2, TW = 5, PW = 8, NP = 4;

    logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
    logic [NQ-1:0]    enq_valid = '0, enq_src0_rdy = '0, enq_src1_rdy = '0;
    logic [NQ*2-1:0]  enq_port = '0;
    logic [NQ*TW-1:0] enq_src0_tag = '0, enq_src1_tag = '0;
    logic [NQ*PW-1:0] enq_payload = '0;
    logic [NQ-1:0]    enq_ready;
    logic             wk_valid = 1'b0;
    logic [TW-1:0]    wk_tag = '0;
    logic [NP-1:0]    unit_busy = '0;
    logic [NP-1:0]    iss_valid;
    logic [NP*QW-1:0] iss_queue;
    logic [NP*PW-1:0] iss_payload;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sq_sched i_sq_sched (.*);

    // Compare one value and report a mismatch.
    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expect an issue on port p from queue q with payload pay.
    task automatic chk_iss(input string req, input int p, input int q, input int pay);
        chk({req, " valid"}, int'(iss_valid[p]), 1);
        chk({req, " queue"}, int'(iss_queue[p*QW +: QW]), q);
        chk({req, " payload"}, int'(iss_payload[p*PW +: PW]), pay);
    endtask

    task automatic put(input int q, input int port, input int t0, input bit r0,
                       input int t1, input bit r1, input int pay);
        enq_valid[q] = 1'b1;
        enq_port[q*2 +: 2] = 2'(port);
        enq_src0_tag[q*TW +: TW] = TW'(t0);
        enq_src0_rdy[q] = r0;
        enq_src1_tag[q*TW +: TW] = TW'(t1);
        enq_src1_rdy[q] = r1;
        enq_payload[q*PW +: PW] = PW'(pay);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        enq_valid = '0;
        wk_valid  = 1'b0;
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: empty after reset
        chk("R1 ready", int'(enq_ready), 15);
        chk("R1 no issue", int'(iss_valid), 0);

        // R2 / R3: fill queue 0 to depth while execution A is busy
        unit_busy = 4'b0100;
        for (int n = 0; n < DEPTH; n++) begin
            put(0, 2, 0, 1, 0, 1, n);
            step();
        end
        #1;
        chk("R2 full", int'(enq_ready[0]), 0);
        chk("R5 busy hold", int'(iss_valid), 0);
        put(0, 2, 0, 1, 0, 1, 99);
        step();
        unit_busy = '0;
        for (int n = 0; n < DEPTH; n++) begin
            #1;
            chk_iss("R3 order", 2, 0, n);
            step();
        end
        #1;
        chk("R2 dropped", int'(iss_valid), 0);

        // R4: blocked head holds a ready younger entry
        put(1, 3, 5, 0, 6, 1, 40);
        step();
        put(1, 3, 0, 1, 0, 1, 41);
        step();
        #1;
        chk("R3 head blocks", int'(iss_valid), 0);
        wk_valid = 1'b1; wk_tag = 5'd6;
        #1;
        chk("R4 wrong tag", int'(iss_valid), 0);
        step();
        #1;
        chk("R4 wrong tag after", int'(iss_valid), 0);
        wk_valid = 1'b1; wk_tag = 5'd5;
        #1;
        chk("R4 not same cycle", int'(iss_valid), 0);
        step();
        #1;
        chk_iss("R4 woken", 3, 1, 40);
        step();
        #1;
        chk_iss("R3 younger", 3, 1, 41);
        step();
        #1;
        chk("R3 drained", int'(iss_valid), 0);

        // R4: wakeup in the enqueue cycle
        put(1, 3, 7, 0, 7, 0, 50);
        wk_valid = 1'b1; wk_tag = 5'd7;
        step();
        #1;
        chk_iss("R4 enqueue wake", 3, 1, 50);
        step();

        // R5: busy blocks, release issues in the same cycle
        unit_busy = 4'b0010;
        put(2, 1, 0, 1, 0, 1, 60);
        step();
        #1;
        chk("R5 busy", int'(iss_valid), 0);
        step();
        #1;
        chk("R5 still busy", int'(iss_valid), 0);
        unit_busy = '0;
        #1;
        chk_iss("R5 release", 1, 2, 60);
        step();

        // R8 / R6: cross-queue bypass and parallel issue
        put(0, 2, 9, 0, 0, 1, 70);
        put(1, 3, 0, 1, 0, 1, 71);
        put(2, 1, 0, 1, 0, 1, 72);
        put(3, 2, 0, 1, 0, 1, 73);
        step();
        #1;
        chk_iss("R8 q1 port3", 3, 1, 71);
        chk_iss("R8 q2 port1", 1, 2, 72);
        chk_iss("R8 q3 passes q0", 2, 3, 73);
        chk("R6 load idle", int'(iss_valid[0]), 0);
        step();
        #1;
        chk("R8 q0 waits", int'(iss_valid), 0);
        wk_valid = 1'b1; wk_tag = 5'd9;
        step();
        #1;
        chk_iss("R8 q0 late", 2, 0, 70);
        step();

        // R7: round-robin on the load port
        unit_busy = 4'b0001;
        for (int r = 0; r < 2; r++) begin
            for (int q = 0; q < NQ; q++) put(q, 0, 0, 1, 0, 1, q * 16 + r);
            step();
        end
        unit_busy = '0;
        for (int r = 0; r < 2; r++) begin
            for (int q = 0; q < NQ; q++) begin
                #1;
                chk_iss("R7 rotate", 0, q, q * 16 + r);
                chk("R7 single grant", $countones(iss_valid), 1);
                step();
            end
        end
        #1;
        chk("R7 drained", int'(iss_valid), 0);

        // R9: flush empties every queue and drops a same-cycle enqueue
        unit_busy = 4'hF;
        for (int q = 0; q < NQ; q++) put(q, q, 0, 1, 0, 1, 80 + q);
        step();
        unit_busy = '0;
        flush = 1'b1;
        put(0, 0, 0, 1, 0, 1, 88);
        #1;
        chk("R9 no issue in flush", int'(iss_valid), 0);
        chk("R9 ready low", int'(enq_ready), 0);
        step();
        flush = 1'b0;
        #1;
        chk("R9 empty", int'(iss_valid), 0);
        chk("R9 ready back", int'(enq_ready), 15);
        step();
        #1;
        chk("R9 still empty", int'(iss_valid), 0);
        put(1, 1, 0, 1, 0, 1, 89);
        step();
        #1;
        chk_iss("R9 works after", 1, 1, 89);
        step();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule